// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It is built from a chain of identical one-bit slices. Each slice can invert either operand and contains an AND gate, an OR gate and a full adder. A four-way selector in each slice picks the result bit. Carries ripple from bit 0 upward. A single negate control both inverts operand B and injects the carry into bit 0, so subtraction reuses the adder as a + ~b + 1.

The four-bit control word is {invert A, negate B, select[1:0]}. The select values are: 00 for the AND path, 01 for the OR path, 10 for the adder sum, and 11 for the less-than input. Signed less-than comparison works through that less-than input. Bit 0 takes the raw adder sum of the top slice, and every other slice has its less-than input tied low. The block also reports three flags: an all-zero result, signed overflow, and the carry out of the top slice.

Top module: `alu_bitslice`

## Requirements
- R1: Control 0000 gives result = a AND b, bit by bit.
- R2: Control 0001 gives result = a OR b.
- R3: Control 0010 gives result = (a + b) modulo 2^WIDTH, and carry_o is bit WIDTH of the unsigned sum.
- R4: Control 0110 gives result = (a - b) modulo 2^WIDTH, formed as a + ~b + 1; carry_o is bit WIDTH of that sum, so it is 1 when a >= b unsigned.
- R5: Control 0111 gives result bits [WIDTH-1:1] = 0, and bit 0 equal to the most significant bit of a + ~b + 1, with no overflow correction. For example, a = 0x80000000 and b = 1 give 0.
- R6: Control 1100 gives result = NOT (a OR b), built as (~a) AND (~b).
- R7: zero_o is 1 exactly when all result bits are 0. Subtracting equal operands therefore raises it.
- R8: ovf_o is the carry into the top slice XOR the carry out of it. For add and subtract, it is 1 exactly when both effective operands share a sign bit and the result sign differs.
- R9: For add, subtract and set-less-than, carry_o is the carry leaving the top slice.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | {invert A, negate B, select[1:0]} |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | All result bits are zero |
| ovf_o | output | 1 | Signed overflow of the adder |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
Three things resolve together: the adder sum of the top slice, the overflow flag, and bit 0 of the result in less-than mode. All three come out of the same ripple pass, and the top-slice sum feeds the less-than input of bit 0. Operand pairs that overflow on subtraction, such as the most negative value against a positive value, make the less-than answer disagree with true signed order. The bench holds the block to the uncorrected sign of a + ~b + 1 in those cases, and in the same cycle checks that the overflow flag is raised and the zero flag matches the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     a_inv;
    logic     b_neg;
    alu_sel_e sel;
  } alu_ctrl_t;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     a_inv_i,
  input  logic     b_neg_i,
  input  logic     carry_i,
  input  logic     less_i,
  input  alu_sel_e sel_i,
  output logic     result_o,
  output logic     carry_o,
  output logic     sum_o
);

  logic a_x;
  logic b_x;

  assign a_x     = a_i ^ a_inv_i;
  assign b_x     = b_i ^ b_neg_i;
  assign sum_o   = a_x ^ b_x ^ carry_i;
  assign carry_o = (a_x & b_x) | (a_x & carry_i) | (b_x & carry_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  result_o = a_x & b_x;
      SEL_OR:   result_o = a_x | b_x;
      SEL_SUM:  result_o = sum_o;
      default:  result_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  localparam int HALF = WIDTH / 2;

  generate
    if (WIDTH == 1) begin : g_leaf
      assign zero_o = ~vec_i[0];
    end else begin : g_split
      logic lo_zero;
      logic hi_zero;
      alu_zero_detect #(.WIDTH(HALF)) u_lo (
        .vec_i  (vec_i[HALF-1:0]),
        .zero_o (lo_zero)
      );
      alu_zero_detect #(.WIDTH(WIDTH-HALF)) u_hi (
        .vec_i  (vec_i[WIDTH-1:HALF]),
        .zero_o (hi_zero)
      );
      assign zero_o = lo_zero & hi_zero;
    end
  endgenerate

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] res_bits;

  assign ctrl     = alu_ctrl_t'(ctrl_i);
  assign carry[0] = ctrl.b_neg;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      logic less_w;
      if (i == 0) begin : g_lsb
        assign less_w = sums[MSB];
      end else begin : g_upper
        assign less_w = 1'b0;
      end
      alu_bit_slice u_slice (
        .a_i      (opa_i[i]),
        .b_i      (opb_i[i]),
        .a_inv_i  (ctrl.a_inv),
        .b_neg_i  (ctrl.b_neg),
        .carry_i  (carry[i]),
        .less_i   (less_w),
        .sel_i    (ctrl.sel),
        .result_o (res_bits[i]),
        .carry_o  (carry[i+1]),
        .sum_o    (sums[i])
      );
    end
  endgenerate

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (res_bits),
    .zero_o (zero_o)
  );

  assign result_o = res_bits;
  assign carry_o  = carry[WIDTH];
  assign ovf_o    = carry[MSB] ^ carry[WIDTH];

  always_comb begin
    if (ctrl_i == CODE_AND)
      AST_AND_PATH: assert (result_o == (opa_i & opb_i)) else $error("and path mismatch"); // R1
    if (ctrl_i == CODE_NOR)
      AST_NOR_PATH: assert (result_o == ~(opa_i | opb_i)) else $error("nor path mismatch"); // R6
    if (ctrl_i == CODE_SLT)
      AST_SLT_UPPER: assert (result_o[MSB:1] == '0) else $error("slt upper bits set"); // R5
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag mismatch"); // R7
    if (ctrl_i == CODE_ADD)
      AST_ADD_OVF: assert (ovf_o == ((opa_i[MSB] == opb_i[MSB]) && (result_o[MSB] != opa_i[MSB])))
        else $error("add overflow mismatch"); // R8
    if (ctrl_i == CODE_SUB)
      AST_SUB_OVF: assert (ovf_o == ((opa_i[MSB] != opb_i[MSB]) && (result_o[MSB] != opa_i[MSB])))
        else $error("sub overflow mismatch"); // R8
  end

endmodule

// File: tb/sim_alu_bitslice.sv
module sim_alu_bitslice;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [3:0]   ctrl;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;
  logic         carry;

  int checks;
  int fails;
  bit done;

  alu_bitslice #(.WIDTH(W)) u0 (
    .opa_i    (opa),
    .opb_i    (opb),
    .ctrl_i   (ctrl),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf),
    .carry_o  (carry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W:0] wide_sum(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    return {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, sub};
  endfunction

  function automatic logic [W-1:0] exp_result(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    logic [W:0] d;
    d = wide_sum(a, b, 1'b1);
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return {{(W-1){1'b0}}, d[W-1]};
      default: return ~(a | b);
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub);
    logic [W-1:0] r;
    logic         bs;
    bs = sub ? ~b[W-1] : b[W-1];
    r  = wide_sum(a, b, sub);
    return (a[W-1] == bs) && (r[W-1] != a[W-1]);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ctrl=%b a=%h b=%h actual=%h expected=%h", tag, ctrl, opa, opb, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    logic [W-1:0] er;
    logic [W:0]   ws;
    string        tag;
    @(posedge clk);
    opa  = a;
    opb  = b;
    ctrl = c;
    @(negedge clk);
    er = exp_result(a, b, c);
    case (c)
      4'b0000: tag = "R1";
      4'b0001: tag = "R2";
      4'b0010: tag = "R3";
      4'b0110: tag = "R4";
      4'b0111: tag = "R5";
      default: tag = "R6";
    endcase
    check(tag, result, er);
    check("R7", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
    if (c == 4'b0010 || c == 4'b0110) begin
      check("R8", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf(a, b, c[2])});
    end
    if (c == 4'b0010 || c == 4'b0110 || c == 4'b0111) begin
      ws = wide_sum(a, b, c[2]);
      check("R9", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, ws[W]});
    end
  endtask

  initial begin
    logic [W-1:0] corners [5];
    logic [3:0]   codes [6];
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001;
    codes[0] = 4'b0000;
    codes[1] = 4'b0001;
    codes[2] = 4'b0010;
    codes[3] = 4'b0110;
    codes[4] = 4'b0111;
    codes[5] = 4'b1100;
    void'($urandom(32'h5EED_0C1D));
    rst_n = 1'b0;
    opa   = '0;
    opb   = '0;
    ctrl  = 4'b0000;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state with all inputs low: AND of zeros
    check("R1", result, '0);
    check("R7", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

    // directed: slt across signed overflow uses raw sign (R5), overflow seen (R8)
    run_op(32'h8000_0000, 32'h0000_0001, 4'b0111);
    check("R5", result, 32'h0);
    run_op(32'h8000_0000, 32'h0000_0001, 4'b0110);
    check("R8", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, 1'b1});
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    check("R5", result, 32'h1);
    // equality through subtraction (R7)
    run_op(32'h1234_5678, 32'h1234_5678, 4'b0110);
    check("R7", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
    // add wraps with carry (R3, R9)
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
    check("R3", result, 32'h0);
    check("R9", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, 1'b1});

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 6; k++)
          run_op(corners[i], corners[j], codes[k]);

    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = $urandom();
      rb = $urandom();
      if (n % 8 == 0) rb = ra;
      if (n % 8 == 1) ra = {1'b1, ra[W-2:0]};
      run_op(ra, rb, codes[n % 6]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule